// File: doc/BRIEF.md
# Configurable GPIO pin bank with polarity and open-drain resolution

This block holds the control state of a bank of general-purpose pins behind a small word-addressed register interface, and resolves from that state both the logical level of every pin and the value software reads back as pin input. No pad model sits outside it: the drive value, the drive enable, push-pull or open-drain output mode, the pull-up and pull-down settings, a per-pin inversion and an input mask together decide each pin.

Inversion acts twice: once on the value sent toward the pin and once on the value sampled back. An enabled push-pull pin therefore reads back the value software wrote. An open-drain pin whose driven value is high lets go of the line, and the line falls back to the pulls. A masked input reads as zero before the inversion is applied. Dedicated set and clear offsets let software change single bits of the drive value and the drive enable without a read-modify-write. An external write-protect input blocks every write while it is high.

Top module: `gpio_pin_bank`

## Requirements
- R1: After reset, drive value, drive enable, output mode, inversion and pull-down read 0, and pull-up and input mask read all ones. Offsets: 0x00 pin input (read-only), 0x04 drive value, 0x08 drive enable, 0x0C output mode (1 = open-drain), 0x10 inversion, 0x14 pull-up, 0x18 pull-down, 0x1C input mask, 0x20 drive set, 0x24 drive clear, 0x28 enable set, 0x2C enable clear.
- R2: A pin with drive enable 1 and output mode 0 takes the level (drive value XOR inversion); its pull bits have no effect.
- R3: A pin with drive enable 0 takes the pull level: 1 when pull-up is 1 and pull-down is 0, otherwise 0 (opposing or absent pulls resolve low); its drive value has no effect.
- R4: A pin with drive enable 1 and output mode 1 is 0 when (drive value XOR inversion) is 0, and takes the pull level of R3 when it is 1.
- R5: Pin input bit = (pin level AND input mask) XOR inversion, so an enabled push-pull pin reads back its drive value whatever its inversion bit.
- R6: An input mask bit of 0 makes that pin input bit equal to its inversion bit.
- R7: A write to a set offset ORs the written ones into its target, a write to a clear offset clears the written ones; the result reads through the target's own offset and the set and clear offsets read 0.
- R8: While the write-protect input is 1, writes to any offset leave every register unchanged.
- R9: Writes to the pin input offset or to an unmapped offset change no register, and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the current address |
| wr_lock | input | 1 | Write protect; 1 blocks all writes |
| addr | input | AW | Byte offset of the register accessed |
| wdata | input | NPINS | Write data |
| rdata | output | NPINS | Read data for `addr`, combinational |
| pin_level | output | NPINS | Resolved level of each pin |

## Verification
The assertions assume that the address and write strobe are stable across each rising edge and that reset is held until the first edge has passed, since the lock and set properties compare register state one cycle after a sampled write. The bench drives every input only on the falling edge and releases reset between edges, so each write is seen by exactly one rising edge. The sweep assigns every one of the 128 combinations of the seven per-pin control bits to some pin of an eight-pin bank, so opposing pulls, absent pulls and masked inverted pins all occur under legal stimulus.

// File: rtl/gpio_pin_bank.sv
module gpio_pin_bank #(
  parameter int NPINS = 32,
  parameter int AW    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_lock,
  input  logic [AW-1:0]    addr,
  input  logic [NPINS-1:0] wdata,
  output logic [NPINS-1:0] rdata,
  output logic [NPINS-1:0] pin_level
);
  localparam logic [AW-1:0] A_PIN   = AW'(6'h00);
  localparam logic [AW-1:0] A_DRV   = AW'(6'h04);
  localparam logic [AW-1:0] A_EN    = AW'(6'h08);
  localparam logic [AW-1:0] A_ODM   = AW'(6'h0C);
  localparam logic [AW-1:0] A_INV   = AW'(6'h10);
  localparam logic [AW-1:0] A_PUP   = AW'(6'h14);
  localparam logic [AW-1:0] A_PDN   = AW'(6'h18);
  localparam logic [AW-1:0] A_MSK   = AW'(6'h1C);
  localparam logic [AW-1:0] A_DRVS  = AW'(6'h20);
  localparam logic [AW-1:0] A_DRVC  = AW'(6'h24);
  localparam logic [AW-1:0] A_ENS   = AW'(6'h28);
  localparam logic [AW-1:0] A_ENC   = AW'(6'h2C);
  localparam logic [NPINS-1:0] ONES = '1;

  logic [NPINS-1:0] drv_q, en_q, odm_q, inv_q, pup_q, pdn_q, msk_q;
  logic [NPINS-1:0] tow_pin, pulled, din;
  logic             acc;

  assign acc = wr_en & ~wr_lock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_q <= '0;
      en_q  <= '0;
      odm_q <= '0;
      inv_q <= '0;
      pup_q <= ONES;
      pdn_q <= '0;
      msk_q <= ONES;
    end else if (acc) begin
      case (addr)
        A_DRV:   drv_q <= wdata;
        A_DRVS:  drv_q <= drv_q | wdata;
        A_DRVC:  drv_q <= drv_q & ~wdata;
        A_EN:    en_q  <= wdata;
        A_ENS:   en_q  <= en_q | wdata;
        A_ENC:   en_q  <= en_q & ~wdata;
        A_ODM:   odm_q <= wdata;
        A_INV:   inv_q <= wdata;
        A_PUP:   pup_q <= wdata;
        A_PDN:   pdn_q <= wdata;
        A_MSK:   msk_q <= wdata;
        default: ;
      endcase
    end
  end

  assign tow_pin   = drv_q ^ inv_q;
  assign pulled    = pup_q & ~pdn_q;
  assign pin_level = (en_q & ~odm_q & tow_pin)
                   | (en_q & odm_q & tow_pin & pulled)
                   | (~en_q & pulled);
  assign din       = (pin_level & msk_q) ^ inv_q;

  always_comb begin
    case (addr)
      A_PIN:   rdata = din;
      A_DRV:   rdata = drv_q;
      A_EN:    rdata = en_q;
      A_ODM:   rdata = odm_q;
      A_INV:   rdata = inv_q;
      A_PUP:   rdata = pup_q;
      A_PDN:   rdata = pdn_q;
      A_MSK:   rdata = msk_q;
      default: rdata = '0;
    endcase
  end
endmodule

module gpio_pin_bank_chk #(
  parameter int NPINS = 32,
  parameter int AW    = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             wr_lock,
  input logic [AW-1:0]    addr,
  input logic [NPINS-1:0] wdata,
  input logic [NPINS-1:0] pin_level,
  input logic [NPINS-1:0] din,
  input logic [NPINS-1:0] drv_q,
  input logic [NPINS-1:0] en_q,
  input logic [NPINS-1:0] odm_q,
  input logic [NPINS-1:0] inv_q,
  input logic [NPINS-1:0] pup_q,
  input logic [NPINS-1:0] msk_q
);
  localparam logic [AW-1:0] A_DRVS = AW'(6'h20);
  localparam logic [AW-1:0] A_ENC  = AW'(6'h2C);

  p_pushpull_readback_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((din ^ drv_q) & en_q & ~odm_q & msk_q) == '0);

  p_masked_reads_inv_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((din ^ inv_q) & ~msk_q) == '0);

  p_undriven_needs_pullup_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_level & ~en_q & ~pup_q) == '0);

  p_opendrain_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_level & en_q & odm_q & ~(drv_q ^ inv_q)) == '0);

  p_lock_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_lock) |=> (drv_q == $past(drv_q) && en_q == $past(en_q)
                            && msk_q == $past(msk_q)));

  p_set_ors_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_lock && addr == A_DRVS) |=> ((drv_q & $past(wdata)) == $past(wdata)));

  p_clear_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_lock && addr == A_ENC) |=> ((en_q & $past(wdata)) == '0));
endmodule

bind gpio_pin_bank gpio_pin_bank_chk #(.NPINS(NPINS), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_lock(wr_lock), .addr(addr),
  .wdata(wdata), .pin_level(pin_level), .din(din), .drv_q(drv_q), .en_q(en_q),
  .odm_q(odm_q), .inv_q(inv_q), .pup_q(pup_q), .msk_q(msk_q)
);

// File: tb/sim_gpio_pin_bank.sv
`timescale 1ns/1ps
module sim_gpio_pin_bank;
  localparam int N  = 8;
  localparam int AW = 6;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, wr_lock = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [N-1:0]  wdata = '0;
  logic [N-1:0]  rdata, pin_level;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_pin_bank #(.NPINS(N), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_lock(wr_lock),
    .addr(addr), .wdata(wdata), .rdata(rdata), .pin_level(pin_level));

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [N-1:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [N-1:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic rchk(input string tag, input logic [AW-1:0] a, input logic [N-1:0] exp);
    logic [N-1:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  initial begin
    logic [N-1:0] d, e, t, p, u, w, m, xp, xd;
    #12 rst_n = 1'b1;

    // R1 reset values and map
    rchk("R1 drive", 6'h04, 8'h00);
    rchk("R1 enable", 6'h08, 8'h00);
    rchk("R1 mode", 6'h0C, 8'h00);
    rchk("R1 inversion", 6'h10, 8'h00);
    rchk("R1 pull-up", 6'h14, 8'hFF);
    rchk("R1 pull-down", 6'h18, 8'h00);
    rchk("R1 mask", 6'h1C, 8'hFF);
    rchk("R1 pin input", 6'h00, 8'hFF);
    chk("R1 pin level", pin_level, 8'hFF);
    rchk("R7 set alias reads 0", 6'h20, 8'h00);

    // R2 R3 R4 R5 R6 sweep: all 128 per-pin control combinations
    for (int r = 0; r < 16; r++) begin
      for (int q = 0; q < N; q++) begin
        logic [6:0] c;
        logic dv, pl, pn;
        c = 7'(r * N + q);
        d[q] = c[0]; e[q] = c[1]; t[q] = c[2]; p[q] = c[3];
        u[q] = c[4]; w[q] = c[5]; m[q] = c[6];
        dv = c[0] ^ c[3];
        pl = c[4] & ~c[5];
        if (!c[1]) pn = pl;
        else if (c[2]) pn = dv ? pl : 1'b0;
        else pn = dv;
        xp[q] = pn;
        xd[q] = (pn & c[6]) ^ c[3];
      end
      wr(6'h04, d); wr(6'h08, e); wr(6'h0C, t); wr(6'h10, p);
      wr(6'h14, u); wr(6'h18, w); wr(6'h1C, m);
      #1 chk($sformatf("R2 R3 R4 pin level round %0d", r), pin_level, xp);
      rchk($sformatf("R5 R6 pin input round %0d", r), 6'h00, xd);
    end

    // R7 set/clear aliases
    wr(6'h04, 8'h5A); wr(6'h20, 8'h81);
    rchk("R7 drive set", 6'h04, 8'hDB);
    wr(6'h24, 8'h0A);
    rchk("R7 drive clear", 6'h04, 8'hD1);
    wr(6'h08, 8'hF0); wr(6'h28, 8'h0F);
    rchk("R7 enable set", 6'h08, 8'hFF);
    wr(6'h2C, 8'h3C);
    rchk("R7 enable clear", 6'h08, 8'hC3);
    rchk("R7 clear alias reads 0", 6'h2C, 8'h00);

    // R8 write protect
    @(negedge clk) wr_lock = 1'b1;
    wr(6'h04, 8'h00); wr(6'h28, 8'hFF); wr(6'h1C, 8'h00);
    rchk("R8 drive held", 6'h04, 8'hD1);
    rchk("R8 enable held", 6'h08, 8'hC3);
    rchk("R8 mask held", 6'h1C, m);
    @(negedge clk) wr_lock = 1'b0;
    wr(6'h04, 8'h24);
    rchk("R8 write after unlock", 6'h04, 8'h24);

    // R9 read-only and unmapped offsets
    wr(6'h00, 8'h00); wr(6'h30, 8'hFF); wr(6'h3C, 8'hFF);
    rchk("R9 drive unchanged", 6'h04, 8'h24);
    rchk("R9 enable unchanged", 6'h08, 8'hC3);
    rchk("R9 pull-up unchanged", 6'h14, u);
    rchk("R9 unmapped reads 0", 6'h30, 8'h00);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule